// File: doc/BRIEF.md
# Priority Interrupt Level Controller

This block decides which interrupting device, if any, may take the processor, and hands the winner to the trap sequencer as a 4-bit vector code with a valid flag. It serves seven general devices and one dedicated device. Each device contributes a ready bit and its own interrupt-enable bit. The controller masks the resulting requests against the processor's current 4-bit level field and breaks ties among simultaneous requests by fixed priority, entirely in hardware.

The level field can be read in one of two ways, chosen by a mode input. In group mode each level bit opens one group of devices, so the useful settings are 0000, 0001, 0011, 0111 and 1111. In threshold mode the three low level bits form a priority threshold and the top bit alone opens the dedicated device. In both modes the dedicated device has the highest priority and takes vector code 15; general device k takes vector code 8+k, so the handler addresses land at 0x80 through 0xF0. The presented vector is registered and held until the sequencer acknowledges it.

Top module: `intr_level_ctrl`

## Requirements
- R1: A device requests only when both its ready bit and its interrupt-enable bit are 1; a ready device with enable 0 never produces an interrupt.
- R2: Level 0000 admits no source in either mode; level 1111 admits every requesting source in either mode.
- R3: In group mode (binary_mode=0), level bit 0 admits general devices 0 and 1, bit 1 admits devices 2 and 3, bit 2 admits devices 4, 5 and 6, and bit 3 admits the dedicated device.
- R4: In threshold mode (binary_mode=1), general device k is admitted only when k is strictly less than cpu_level[2:0], and the dedicated device is admitted exactly when cpu_level[3] is 1.
- R5: General device k presents vector code 8+k; the dedicated device presents vector code 15.
- R6: Among admitted requests, the one with the highest vector code wins.
- R7: When no source is admitted and no vector is held, the outputs one clock later are irq_valid=0 and irq_vector=0.
- R8: While a presented source stays admitted and seq_ack is 0, irq_valid stays 1 and irq_vector does not change, even if a higher-priority request arrives.
- R9: seq_ack with a presented source still admitted is accepted: the next cycle shows irq_valid=0 and irq_vector=0, and arbitration resumes the cycle after.
- R10: If the presented source is no longer admitted, seq_ack is ignored and the output takes the current arbitration result on the next clock.
- R11: During and right after reset irq_valid=0 and irq_vector=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| binary_mode | input | 1 | 1 selects threshold reading of the level, 0 selects group reading |
| cpu_level | input | 4 | Current processor level field |
| gen_ready | input | 7 | Ready bits of the general devices |
| gen_ie | input | 7 | Interrupt-enable bits of the general devices |
| ded_ready | input | 1 | Ready bit of the dedicated device |
| ded_ie | input | 1 | Interrupt-enable bit of the dedicated device |
| seq_ack | input | 1 | Sequencer accepts the presented vector |
| irq_valid | output | 1 | A vector is being presented |
| irq_vector | output | 4 | Vector code 8..15, or 0 when none |

## Verification
The bench aims at the threshold edge in threshold mode, where device k equal to the level value must stay masked; an off-by-one comparator would let it through and present a vector one code too high. It also drives a higher-priority request while a vector is held, which a design that re-arbitrates every cycle would let replace the held code, and raises an acknowledge after the held request was withdrawn, which a careless handshake would accept and so drop a live interrupt. Group mode is checked with each single level bit to catch a swapped group mapping, and long random runs mix modes, levels and acknowledges against a bench model.

// File: rtl/pilc_pkg.sv
package pilc_pkg;
  localparam int NGEN     = 7;
  localparam int NSRC     = NGEN + 1;
  localparam int LVL_W    = 4;
  localparam int THR_W    = LVL_W - 1;
  localparam int VEC_W    = 4;
  localparam int VEC_BASE = 8;
  localparam int IDX_W    = $clog2(NSRC);

  // level bit that opens source k in group mode
  function automatic int group_bit(input int k);
    if (k >= NGEN)     return LVL_W - 1;
    else if (k < 2)    return 0;
    else if (k < 4)    return 1;
    else               return 2;
  endfunction

  // threshold test for a general source in threshold mode
  function automatic logic below_thr(input int k, input logic [THR_W-1:0] thr);
    return (k < int'(thr));
  endfunction

  function automatic logic [VEC_W-1:0] code_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx);
  endfunction
endpackage

// File: rtl/pilc_req_gate.sv
module pilc_req_gate
  import pilc_pkg::*;
(
  input  logic [NGEN-1:0] gen_ready,
  input  logic [NGEN-1:0] gen_ie,
  input  logic            ded_ready,
  input  logic            ded_ie,
  output logic [NSRC-1:0] req
);
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_src
      if (i < NGEN) begin : g_gen
        assign req[i] = gen_ready[i] & gen_ie[i];
      end else begin : g_ded
        assign req[i] = ded_ready & ded_ie;
      end
    end
  endgenerate
endmodule

// File: rtl/pilc_level_mask.sv
module pilc_level_mask
  import pilc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             binary_mode,
  input  logic [LVL_W-1:0] cpu_level,
  input  logic [NSRC-1:0]  req,
  output logic [NSRC-1:0]  admit
);
  logic [NSRC-1:0] open_bits;
  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_open
      if (i == NSRC - 1) begin : g_ded
        assign open_bits[i] = cpu_level[LVL_W-1];
      end else begin : g_gen
        assign open_bits[i] = binary_mode ? below_thr(i, cpu_level[THR_W-1:0])
                                          : cpu_level[group_bit(i)];
      end
    end
  endgenerate

  assign admit = req & open_bits;

  a_r2_level_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level == '0) |-> (admit == '0));
  a_r2_level_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level == '1) |-> (admit == req));
endmodule

// File: rtl/pilc_prio_pick.sv
module pilc_prio_pick
  import pilc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  admit,
  output logic             any,
  output logic [IDX_W-1:0] win_idx,
  output logic [NSRC-1:0]  grant
);
  logic [NSRC:0] above;
  assign above[NSRC] = 1'b0;

  genvar i;
  generate
    for (i = NSRC - 1; i >= 0; i--) begin : g_chain
      assign above[i] = above[i+1] | admit[i];
      assign grant[i] = admit[i] & ~above[i+1];
    end
  endgenerate

  assign any = above[0];

  always_comb begin
    win_idx = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (grant[k]) win_idx = IDX_W'(k);
    end
  end

  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/intr_level_ctrl.sv
module intr_level_ctrl
  import pilc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        binary_mode,
  input  logic [3:0]  cpu_level,
  input  logic [6:0]  gen_ready,
  input  logic [6:0]  gen_ie,
  input  logic        ded_ready,
  input  logic        ded_ie,
  input  logic        seq_ack,
  output logic        irq_valid,
  output logic [3:0]  irq_vector
);
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  admit;
  logic [NSRC-1:0]  grant;
  logic             any;
  logic [IDX_W-1:0] win_idx;

  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  // named events for the checks
  logic held_live;
  logic ack_taken;
  logic rearb;

  pilc_req_gate u_gate (
    .gen_ready (gen_ready),
    .gen_ie    (gen_ie),
    .ded_ready (ded_ready),
    .ded_ie    (ded_ie),
    .req       (req)
  );

  pilc_level_mask u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .binary_mode (binary_mode),
    .cpu_level   (cpu_level),
    .req         (req),
    .admit       (admit)
  );

  pilc_prio_pick u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .admit   (admit),
    .any     (any),
    .win_idx (win_idx),
    .grant   (grant)
  );

  assign held_live = valid_q & admit[idx_q];
  assign ack_taken = held_live & seq_ack;
  assign rearb     = ~held_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
    end else if (ack_taken) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else if (rearb) begin
      valid_q <= any;
      idx_q   <= win_idx;
      vec_q   <= any ? code_of(win_idx) : '0;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = vec_q;

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (held_live && !seq_ack) |=> (irq_valid && $stable(irq_vector)));
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_taken |=> (!irq_valid && irq_vector == '0));
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_vector == '0));
  a_r5_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VEC_W'(VEC_BASE)));
  a_r10_new_win: assert property (@(posedge clk) disable iff (!rst_n)
    (rearb && !any) |=> !irq_valid);
endmodule

// File: tb/intr_level_ctrl_tb.sv
module intr_level_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       binary_mode = 1'b0;
  logic [3:0] cpu_level = 4'd0;
  logic [6:0] gen_ready = '0;
  logic [6:0] gen_ie = '0;
  logic       ded_ready = 1'b0;
  logic       ded_ie = 1'b0;
  logic       seq_ack = 1'b0;
  logic       irq_valid;
  logic [3:0] irq_vector;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  logic       m_valid = 1'b0;
  logic [3:0] m_vec = 4'd0;
  string      m_tag = "R11";

  always #2.5 clk = ~clk;

  intr_level_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .binary_mode (binary_mode),
    .cpu_level   (cpu_level),
    .gen_ready   (gen_ready),
    .gen_ie      (gen_ie),
    .ded_ready   (ded_ready),
    .ded_ie      (ded_ie),
    .seq_ack     (seq_ack),
    .irq_valid   (irq_valid),
    .irq_vector  (irq_vector)
  );

  // R3/R4: is code c (8..15) currently admitted
  function automatic logic code_ok(input logic [3:0] c);
    logic ready_bit, lvl_ok;
    int k = int'(c) - 8;
    if (k < 0) return 1'b0;
    if (k == 7) ready_bit = ded_ready & ded_ie;
    else        ready_bit = gen_ready[k] & gen_ie[k];
    if (k == 7) lvl_ok = cpu_level[3];
    else if (binary_mode) lvl_ok = (k < int'(cpu_level[2:0]));
    else case (k)
      0, 1:    lvl_ok = cpu_level[0];
      2, 3:    lvl_ok = cpu_level[1];
      default: lvl_ok = cpu_level[2];
    endcase
    return ready_bit & lvl_ok;
  endfunction

  // R6: best admitted code, 0 when none
  function automatic logic [3:0] best_code();
    for (int c = 15; c >= 8; c--) if (code_ok(4'(c))) return 4'(c);
    return 4'd0;
  endfunction

  task automatic model_edge();
    logic [3:0] b;
    if (!rst_n) begin
      m_valid = 0; m_vec = 0; m_tag = "R11";
    end else if (m_valid && code_ok(m_vec)) begin
      if (seq_ack) begin m_valid = 0; m_vec = 0; m_tag = "R9"; end
      else m_tag = "R8";
    end else begin
      b = best_code();
      m_tag = m_valid ? "R10" : (b == 0 ? "R7" : "R6");
      m_valid = (b != 0); m_vec = b;
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (irq_valid !== m_valid || irq_vector !== m_vec) begin
      bad++;
      $display("FAIL %s: got valid=%0b vec=%0d expected valid=%0b vec=%0d",
               tag, irq_valid, irq_vector, m_valid, m_vec);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag == "" ? m_tag : tag);
  endtask

  task automatic setin(input logic bm, input logic [3:0] lv, input logic [6:0] rd,
                       input logic [6:0] ie, input logic dr, input logic di, input logic ak);
    binary_mode = bm; cpu_level = lv; gen_ready = rd; gen_ie = ie;
    ded_ready = dr; ded_ie = di; seq_ack = ak;
  endtask

  task automatic drain();
    setin(0, 0, 0, 0, 0, 0, 0);
    step(""); step("");
  endtask

  initial begin
    void'($urandom(32'h1a2b3c));
    @(negedge clk);
    step("R11");
    rst_n = 1'b1;
    @(negedge clk);
    check("R11");

    // R2 level zero masks everything in both modes
    setin(0, 4'b0000, 7'h7f, 7'h7f, 1, 1, 0); step("R2");
    setin(1, 4'b0000, 7'h7f, 7'h7f, 1, 1, 0); step("R2");
    // R2 full level, group mode -> dedicated, code 15
    setin(0, 4'b1111, 7'h7f, 7'h7f, 1, 1, 0); step("R2");
    drain();
    // R2 full level, threshold mode, only device 6 -> 14
    setin(1, 4'b1111, 7'h40, 7'h40, 0, 0, 0); step("R2");
    drain();
    // R1 ready without enable is ignored
    setin(0, 4'b1111, 7'h7f, 7'h00, 1, 0, 0); step("R1"); step("R1");
    // R3 group mode, level 0001: devices 0 and 2 request -> 8
    setin(0, 4'b0001, 7'h05, 7'h7f, 0, 0, 0); step("R3");
    drain();
    // R3 level 0010 alone: device 3 -> 11 and device 4 masked
    setin(0, 4'b0010, 7'h18, 7'h7f, 0, 0, 0); step("R3");
    drain();
    // R3 level 0100: devices 4..6 open -> 14
    setin(0, 4'b0100, 7'h70, 7'h7f, 1, 1, 0); step("R3");
    drain();
    // R4 threshold 3: device 3 masked at the edge, device 2 wins -> 10
    setin(1, 4'b0011, 7'h0c, 7'h7f, 0, 0, 0); step("R4");
    drain();
    // R4 dedicated only by top bit: level 1000 -> 15
    setin(1, 4'b1000, 7'h01, 7'h7f, 1, 1, 0); step("R4");
    drain();
    // R5 device 5 alone, threshold 6 -> 13
    setin(1, 4'b0110, 7'h20, 7'h7f, 0, 0, 0); step("R5");
    // R8 higher request arrives while held
    setin(1, 4'b1111, 7'h60, 7'h7f, 0, 0, 0); step("R8"); step("R8");
    // R9 ack accepted
    seq_ack = 1; step("R9");
    seq_ack = 0; step("R6");
    // R10 withdraw held request (device 6), ack ignored
    setin(1, 4'b1111, 7'h01, 7'h7f, 0, 0, 1); step("R10");
    seq_ack = 0;
    drain();
    // R7 nothing admitted
    step("R7");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      binary_mode = r[0];
      cpu_level   = r[2] ? 4'b1111 : r[7:4];
      if (r[3]) begin gen_ready = r[14:8]; gen_ie = r[22:16]; end
      ded_ready   = r[23]; ded_ie = r[24];
      seq_ack     = r[25] & r[26];
      step("");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    total++; bad++;
    $display("FAIL watchdog: got cycles=%0d expected fewer", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule